// File: doc/BRIEF.md
# Shifted-Operand ALU with Condition Flags

This block is the data-processing step of a 32-bit integer pipeline. The second operand first passes through a barrel shifter. The shifted value and the first operand then enter an arithmetic/logic stage. That stage produces a result word, a register write enable and the next value of the four condition flags (negative, zero, carry, overflow). Decoding and the register file sit outside the block. The decoder supplies the opcode, the shift kind, the shift amount, the set-flags bit and the current flags.

Each operation is offered on a valid/ready input and comes out on a valid/ready output after one registered stage. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. The input is ready whenever the output register is empty or is being drained in the same cycle, so `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output stays frozen and no new operation is taken. The consumer may hold `out_ready` low for any number of cycles.

Opcodes (4 bits): 0 AND, 1 XOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 OR, 13 MOV, 14 BIC, 15 MVN. Shift kinds (3 bits): 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX; codes 5 to 7 pass the operand and the carry through unchanged. The flag vectors are ordered [3]=N, [2]=Z, [1]=C, [0]=V.

Top module: `bsalu_unit`

## Requirements
- R1: An operation accepted on an edge appears on the outputs after that edge with `out_valid` high. While `out_valid && !out_ready`, the outputs hold their values and `in_ready` is low.
- R2: With a shift amount a from 1 to 31, LSL, LSR, ASR and ROR shift rm by a. The shifter carry is the last bit shifted out. For ROR the carry is bit 31 of the rotated result.
- R3: A shift amount of 0 passes rm through unchanged, and the shifter carry equals the incoming C. RRX ignores the amount: it produces {C, rm[31:1]} with carry rm[0].
- R4: LSL or LSR by exactly 32 gives 0, with carry rm[0] or rm[31] respectively. By more than 32 they give 0 with carry 0. ASR by 32 or more gives 32 copies of rm[31], with carry rm[31]. ROR by a nonzero multiple of 32 gives rm, with carry rm[31].
- R5: AND, XOR, OR, MOV, MVN (NOT N) and BIC (rn AND NOT N) with S set take N and Z from the result and C from the shifter carry, and leave V unchanged.
- R6: ADD = rn+N, ADC = rn+N+C, SUB = rn−N, SBC = rn−N−!C, RSB = N−rn, RSC = N−rn−!C, all modulo 2^32.
- R7: For arithmetic operations with S set, C is the carry out of bit 31, so for subtraction C=1 means no borrow (1−1 gives Z=1, C=1). V is set on signed overflow.
- R8: TST, TEQ, CMP and CMN compute rn&N, rn^N, rn−N and rn+N for the flags only, and `rd_we` is 0.
- R9: With S clear, `flags_out` equals `flags_in`.
- R10: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| rn | input | 32 | First operand |
| rm | input | 32 | Operand fed to the shifter |
| shift_kind | input | 3 | Shift kind code |
| shift_amt | input | 8 | Shift amount |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Update flags when high |
| flags_in | input | 4 | Current NZCV |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| rd | output | 32 | Result word |
| rd_we | output | 1 | Result should be written |
| flags_out | output | 4 | Next NZCV |

## Verification
The assertions assume the consumer's `out_ready` and the producer's operand fields are known values and do not change between edges. They also assume an offered operation is not changed until it is taken. The bench drives every input at the falling edge. It raises `in_valid` for one cycle only, at a point where `in_ready` is already high, or keeps it raised during a deliberate stall. Random operand fields are drawn from the full legal code ranges. Shift amounts are biased toward 0, 32 and values above 32.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_XOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    SH_LSL = 3'd0, SH_LSR = 3'd1, SH_ASR = 3'd2, SH_ROR = 3'd3, SH_RRX = 3'd4
  } shift_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic op_is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_logical(input logic [3:0] op);
    return (op == OP_AND) || (op == OP_XOR) || (op == OP_TST) || (op == OP_TEQ) ||
           (op == OP_ORR) || (op == OP_MOV) || (op == OP_BIC) || (op == OP_MVN);
  endfunction

endpackage

// File: rtl/bsalu_shifter.sv
module bsalu_shifter #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [W-1:0]  operand,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  result,
  output logic          cout
);
  import bsalu_pkg::*;

  localparam int LW = $clog2(W);

  logic [W:0]          lsl_full;
  logic [W:0]          lsr_full;
  logic signed [W:0]   asr_full;
  logic [AW-1:0]       asr_amt;
  logic [LW-1:0]       rot_r;
  logic [LW:0]         rot_l;
  logic [W-1:0]        rot;

  always_comb begin
    lsl_full = {1'b0, operand} << amt;
    lsr_full = {operand, 1'b0} >> amt;
    asr_amt  = (amt >= AW'(W)) ? AW'(W) : amt;
    asr_full = $signed({operand, 1'b0}) >>> asr_amt;
    rot_r    = amt[LW-1:0];
    rot_l    = (LW+1)'(W) - {1'b0, rot_r};
    rot      = (operand >> rot_r) | (operand << rot_l);

    result = operand;
    cout   = cin;
    if (kind == SH_RRX) begin
      result = {cin, operand[W-1:1]};
      cout   = operand[0];
    end else if (amt != '0) begin
      case (kind)
        SH_LSL: begin result = lsl_full[W-1:0]; cout = lsl_full[W]; end
        SH_LSR: begin result = lsr_full[W:1];   cout = lsr_full[0]; end
        SH_ASR: begin result = asr_full[W:1];   cout = asr_full[0]; end
        SH_ROR: begin result = rot;             cout = rot[W-1];    end
        default: begin result = operand;        cout = cin;         end
      endcase
    end
  end

endmodule

// File: rtl/bsalu_core.sv
module bsalu_core #(
  parameter int W = 32
) (
  input  logic [W-1:0]       rn,
  input  logic [W-1:0]       opnd,
  input  logic               sh_c,
  input  logic [3:0]         op,
  input  bsalu_pkg::flags_t  flags_in,
  output logic [W-1:0]       result,
  output bsalu_pkg::flags_t  flags_calc,
  output logic               writes
);
  import bsalu_pkg::*;

  logic [W-1:0] add_a;
  logic [W-1:0] add_b;
  logic         add_c;
  logic [W:0]   sum;
  logic         ovf;
  logic         is_log;

  always_comb begin
    add_a = rn;
    add_b = opnd;
    add_c = 1'b0;
    case (op)
      OP_ADC:         add_c = flags_in.c;
      OP_SUB, OP_CMP: begin add_b = ~opnd; add_c = 1'b1; end
      OP_SBC:         begin add_b = ~opnd; add_c = flags_in.c; end
      OP_RSB:         begin add_a = opnd; add_b = ~rn; add_c = 1'b1; end
      OP_RSC:         begin add_a = opnd; add_b = ~rn; add_c = flags_in.c; end
      default:        ;
    endcase
    sum = {1'b0, add_a} + {1'b0, add_b} + {{W{1'b0}}, add_c};
    ovf = (add_a[W-1] == add_b[W-1]) && (sum[W-1] != add_a[W-1]);

    is_log = op_is_logical(op);
    case (op)
      OP_AND, OP_TST: result = rn & opnd;
      OP_XOR, OP_TEQ: result = rn ^ opnd;
      OP_ORR:         result = rn | opnd;
      OP_MOV:         result = opnd;
      OP_BIC:         result = rn & ~opnd;
      OP_MVN:         result = ~opnd;
      default:        result = sum[W-1:0];
    endcase

    flags_calc.n = result[W-1];
    flags_calc.z = (result == '0);
    flags_calc.c = is_log ? sh_c : sum[W];
    flags_calc.v = is_log ? flags_in.v : ovf;
    writes       = !op_is_compare(op);
  end

endmodule

// File: rtl/bsalu_unit.sv
module bsalu_unit #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  rn,
  input  logic [W-1:0]  rm,
  input  logic [2:0]    shift_kind,
  input  logic [AW-1:0] shift_amt,
  input  logic [3:0]    opcode,
  input  logic          set_flags,
  input  logic [3:0]    flags_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  rd,
  output logic          rd_we,
  output logic [3:0]    flags_out
);
  import bsalu_pkg::*;

  logic [W-1:0] sh_res;
  logic         sh_c;
  logic [W-1:0] alu_res;
  flags_t       alu_flags;
  flags_t       cur_flags;
  logic         alu_writes;
  logic         take;

  assign cur_flags = flags_t'(flags_in);
  assign in_ready  = !out_valid || out_ready;
  assign take      = in_valid && in_ready;

  bsalu_shifter #(.W(W), .AW(AW)) u_shift (
    .operand (rm),
    .kind    (shift_kind),
    .amt     (shift_amt),
    .cin     (cur_flags.c),
    .result  (sh_res),
    .cout    (sh_c)
  );

  bsalu_core #(.W(W)) u_core (
    .rn         (rn),
    .opnd       (sh_res),
    .sh_c       (sh_c),
    .op         (opcode),
    .flags_in   (cur_flags),
    .result     (alu_res),
    .flags_calc (alu_flags),
    .writes     (alu_writes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rd        <= '0;
      rd_we     <= 1'b0;
      flags_out <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        rd        <= alu_res;
        rd_we     <= alu_writes;
        flags_out <= set_flags ? 4'(alu_flags) : flags_in;
      end
    end
  end

  // R1
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(rd) && $stable(rd_we) && $stable(flags_out));

  // R8
  compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_is_compare(opcode) |=> !rd_we);

  // R9
  flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !set_flags |=> flags_out == $past(flags_in));

  // R5
  logic_v_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && set_flags && op_is_logical(opcode) |=> flags_out[0] == $past(flags_in[0]));

  // R7
  sub_zero_no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && set_flags && (opcode == OP_SUB || opcode == OP_CMP) |=> !flags_out[2] || flags_out[1]);

endmodule

// File: tb/sim_bsalu_unit.sv
module sim_bsalu_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] rn, rm;
  logic [2:0]  shift_kind;
  logic [7:0]  shift_amt;
  logic [3:0]  opcode;
  logic        set_flags;
  logic [3:0]  flags_in;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] rd;
  logic        rd_we;
  logic [3:0]  flags_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  bsalu_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .rn(rn), .rm(rm), .shift_kind(shift_kind), .shift_amt(shift_amt),
    .opcode(opcode), .set_flags(set_flags), .flags_in(flags_in),
    .out_valid(out_valid), .out_ready(out_ready), .rd(rd), .rd_we(rd_we),
    .flags_out(flags_out)
  );

  function automatic logic [36:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                        input logic [2:0] k, input logic [7:0] amt, input logic s,
                                        input logic [3:0] fl);
    logic [31:0] v;
    logic        sc;
    logic [31:0] r;
    logic [31:0] x, y;
    logic        nc, nv, is_log, is_add, extra, we;
    longint      ux, uy, sx, sy, st;
    logic [3:0]  fo;
    v = b; sc = fl[1];
    if (k == 3'd4) begin
      sc = b[0]; v = {fl[1], b[31:1]};
    end else if (amt != 0 && k <= 3'd3) begin
      for (int i = 0; i < int'(amt); i++) begin
        case (k)
          3'd0: begin sc = v[31]; v = v << 1; end
          3'd1: begin sc = v[0];  v = v >> 1; end
          3'd2: begin sc = v[0];  v = {v[31], v[31:1]}; end
          default: begin v = {v[0], v[31:1]}; sc = v[31]; end
        endcase
      end
    end
    is_log = 1'b1; is_add = 1'b0; extra = 1'b0; x = a; y = v;
    r = 32'd0;
    case (op)
      4'd0, 4'd8:  r = a & v;
      4'd1, 4'd9:  r = a ^ v;
      4'd12:       r = a | v;
      4'd13:       r = v;
      4'd14:       r = a & ~v;
      4'd15:       r = ~v;
      4'd4, 4'd11: begin is_log = 0; is_add = 1; end
      4'd5:        begin is_log = 0; is_add = 1; extra = fl[1]; end
      4'd2, 4'd10: begin is_log = 0; end
      4'd6:        begin is_log = 0; extra = !fl[1]; end
      4'd3:        begin is_log = 0; x = v; y = a; end
      default:     begin is_log = 0; x = v; y = a; extra = !fl[1]; end
    endcase
    nc = sc; nv = fl[0];
    if (!is_log) begin
      ux = longint'({32'd0, x}); uy = longint'({32'd0, y});
      sx = longint'($signed(x)); sy = longint'($signed(y));
      if (is_add) begin
        r  = x + y + {31'd0, extra};
        nc = (ux + uy + longint'(extra)) >= 64'sh1_0000_0000;
        st = sx + sy + longint'(extra);
      end else begin
        r  = x - y - {31'd0, extra};
        nc = ux >= (uy + longint'(extra));
        st = sx - sy - longint'(extra);
      end
      nv = (st > 64'sd2147483647) || (st < -64'sd2147483648);
    end
    we = !(op >= 4'd8 && op <= 4'd11);
    fo = s ? {r[31], r == 32'd0, nc, nv} : fl;
    return {we, fo, r};
  endfunction

  task automatic chk(input string req, input logic [36:0] got, input logic [36:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [2:0] k, input logic [7:0] amt, input logic s, input logic [3:0] fl);
    @(negedge clk);
    opcode = op; rn = a; rm = b; shift_kind = k; shift_amt = amt; set_flags = s; flags_in = fl;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, {4'd0, out_valid, rd_we, flags_out, rd}, {4'd0, 1'b1, model(op, a, b, k, amt, s, fl)});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2417));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    rn = '0; rm = '0; shift_kind = '0; shift_amt = '0; opcode = '0; set_flags = 1'b0; flags_in = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", {35'd0, out_valid, in_ready}, {35'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", {35'd0, out_valid, in_ready}, {35'd0, 1'b0, 1'b1});

    // R5 MOV with LSL #1 of 0x80000004, carry comes from shifter
    run_op("R5", 4'd13, 32'd0, 32'h8000_0004, 3'd0, 8'd1, 1'b1, 4'b0000);
    chk("R5", {rd_we, flags_out, rd}, {1'b1, 4'b0010, 32'h0000_0008});
    // R7 one minus one
    run_op("R7", 4'd2, 32'd1, 32'd1, 3'd0, 8'd0, 1'b1, 4'b0000);
    chk("R7", {rd_we, flags_out, rd}, {1'b1, 4'b0110, 32'h0});
    // R8 compare equal, no write
    run_op("R8", 4'd10, 32'd4, 32'd4, 3'd0, 8'd0, 1'b1, 4'b0000);
    chk("R8", {rd_we, flags_out, rd}, {1'b0, 4'b0110, 32'h0});
    // R6 reverse subtract from zero
    run_op("R6", 4'd3, 32'h77, 32'd0, 3'd0, 8'd0, 1'b0, 4'b0000);
    chk("R6", {5'd0, rd}, {5'd0, 32'hFFFF_FF89});
    // R6 add with shifted self
    run_op("R6", 4'd4, 32'd5, 32'd5, 3'd0, 8'd1, 1'b0, 4'b0000);
    chk("R6", {5'd0, rd}, {5'd0, 32'hF});
    // R5 OR and bit clear
    run_op("R5", 4'd12, 32'h0204_0608, 32'h1030_5070, 3'd0, 8'd0, 1'b0, 4'b0000);
    chk("R5", {5'd0, rd}, {5'd0, 32'h1234_5678});
    run_op("R5", 4'd14, 32'hF, 32'h5, 3'd0, 8'd0, 1'b1, 4'b0011);
    chk("R5", {rd_we, flags_out, rd}, {1'b1, 4'b0011, 32'hA});
    // R6 R7 add with carry overflow
    run_op("R7", 4'd5, 32'h7FFF_FFFF, 32'd0, 3'd0, 8'd0, 1'b1, 4'b0010);
    chk("R7", {rd_we, flags_out, rd}, {1'b1, 4'b1001, 32'h8000_0000});
    // R4 boundary shifts
    run_op("R4", 4'd13, 32'd0, 32'h0000_0001, 3'd0, 8'd32, 1'b1, 4'b0000);
    chk("R4", {rd_we, flags_out, rd}, {1'b1, 4'b0110, 32'h0});
    run_op("R4", 4'd13, 32'd0, 32'h8000_0000, 3'd1, 8'd32, 1'b1, 4'b0000);
    chk("R4", {rd_we, flags_out, rd}, {1'b1, 4'b0110, 32'h0});
    run_op("R4", 4'd13, 32'd0, 32'hFFFF_FFFF, 3'd1, 8'd33, 1'b1, 4'b0010);
    chk("R4", {rd_we, flags_out, rd}, {1'b1, 4'b0100, 32'h0});
    run_op("R4", 4'd13, 32'd0, 32'h8000_0000, 3'd2, 8'd40, 1'b1, 4'b0000);
    chk("R4", {rd_we, flags_out, rd}, {1'b1, 4'b1010, 32'hFFFF_FFFF});
    run_op("R4", 4'd13, 32'd0, 32'h8000_0001, 3'd3, 8'd64, 1'b1, 4'b0000);
    chk("R4", {rd_we, flags_out, rd}, {1'b1, 4'b1010, 32'h8000_0001});
    // R3 amount zero and rotate-with-extend
    run_op("R3", 4'd13, 32'd0, 32'h1234_5678, 3'd1, 8'd0, 1'b1, 4'b0010);
    chk("R3", {rd_we, flags_out, rd}, {1'b1, 4'b0010, 32'h1234_5678});
    run_op("R3", 4'd13, 32'd0, 32'h0000_0003, 3'd4, 8'd9, 1'b1, 4'b0010);
    chk("R3", {rd_we, flags_out, rd}, {1'b1, 4'b1010, 32'h8000_0001});
    // R2 rotate by 4
    run_op("R2", 4'd13, 32'd0, 32'h0000_00F8, 3'd3, 8'd4, 1'b1, 4'b0000);
    chk("R2", {rd_we, flags_out, rd}, {1'b1, 4'b1010, 32'h8000_000F});
    // R9 flags untouched with S clear
    run_op("R9", 4'd2, 32'd0, 32'd1, 3'd0, 8'd0, 1'b0, 4'b0101);
    chk("R9", {rd_we, flags_out, rd}, {1'b1, 4'b0101, 32'hFFFF_FFFF});

    // R1 stall: drain, then hold output
    @(negedge clk);
    out_ready = 1'b0;
    opcode = 4'd4; rn = 32'd10; rm = 32'd20; shift_kind = 3'd0; shift_amt = 8'd0;
    set_flags = 1'b1; flags_in = 4'b0000; in_valid = 1'b1;
    @(negedge clk);
    chk("R1", {out_valid, in_ready, rd_we, flags_out, rd}, {1'b1, 1'b0, 1'b1, 4'b0000, 32'd30});
    opcode = 4'd2; rn = 32'd3; rm = 32'd5;
    @(negedge clk);
    @(negedge clk);
    chk("R1", {out_valid, in_ready, rd_we, flags_out, rd}, {1'b1, 1'b0, 1'b1, 4'b0000, 32'd30});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", {out_valid, in_ready, rd_we, flags_out, rd}, {1'b1, 1'b1, 1'b1, 4'b1000, 32'hFFFF_FFFE});
    @(negedge clk);
    chk("R1", {35'd0, out_valid, in_ready}, {35'd0, 1'b0, 1'b1});

    // Random mix covers R2 R5 R6 R7 R8 R9
    for (int i = 0; i < 800; i++) begin
      logic [7:0] amt;
      logic [31:0] a, b;
      case ($urandom % 6)
        0: amt = 8'd0;
        1: amt = 8'd32;
        2: amt = 8'(32 + $urandom % 8);
        3: amt = 8'($urandom);
        default: amt = 8'(1 + $urandom % 31);
      endcase
      a = ($urandom % 8 == 0) ? 32'h8000_0000 : $urandom;
      b = ($urandom % 8 == 0) ? a : $urandom;
      run_op("R6", 4'($urandom), a, b, 3'($urandom % 8), amt, 1'($urandom), 4'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule